// File: doc/BRIEF.md
# Power-Fail Bus Guard

This block sits between a parallel memory-style bus and an internal byte array. It turns the four bus controls into read, write and idle actions: an active-low select, an active-high select, an active-low output enable and an active-low write strobe. The bus controls are sampled on the block clock. A write is buffered while the strobe is held. It reaches the array only when the write ends, so a write cut short by a supply failure leaves every location untouched.

Two supply comparator inputs govern access. The upper one marks the deselect threshold. While the supply is below it, no data is driven and every bus input is ignored. After the supply recovers, access stays blocked for a programmed number of clock cycles, and any new dip restarts that wait. The lower comparator selects the battery through a registered output.

Each time the supply comes up, the block samples a battery comparator and updates a read-only low-battery bit that appears in one byte of the address space.

Top module: `pfail_bus_ctrl`

## Requirements
- R1: A write is active only while selN=0, selP=1 and weN=0 and access is open. The address and data of the last active cycle are written to the array, with memWe high, in the first cycle where the write is no longer active.
- R2: rdDrive is 1, and rdData shows the addressed byte, only while selN=0, selP=1, oeN=0 and weN=1 and access is open. In every other case rdDrive is 0 and rdData is 0.
- R3: Pulling weN low during a read stops the drive in that same cycle. A write whose selects and strobe become active together never drives data. In the cycle a buffered write commits, no read data is driven.
- R4: While belowTrip is 1, rdDrive and memWe stay 0, and bus inputs have no lasting effect.
- R5: battSel equals the value belowSwitch had at the previous clock edge.
- R6: Access opens only after REC_CYCLES consecutive clock edges with belowTrip at 0 in the recovering state. A 1 on belowTrip during that wait returns the block to the powered-down state and restarts the count.
- R7: A write still active when belowTrip rises is dropped, and it is not committed later.
- R8: When a read targets FLAG_ADDR (0x1FFD), bit 6 of rdData is the low-battery flag, whatever was written to bit 6. The flag is recomputed at each power-up edge, the first edge with belowTrip=0 after the powered-down state, as battLowCmp AND the enable bit. The enable bit is bit 7 of the last byte committed to FLAG_ADDR.
- R9: After reset the block is powered down and blocks access. battSel, the enable bit and the flag are 0, and rdDrive and memWe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selN | input | 1 | Active-low bus select |
| selP | input | 1 | Active-high bus select |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Bus address |
| wrData | input | DATA_W | Bus write data |
| rdData | output | DATA_W | Read data, 0 when not driven |
| rdDrive | output | 1 | Bus drive enable for read data (0 = high impedance) |
| memWe | output | 1 | Array write strobe |
| memAddr | output | ADDR_W | Array address |
| memWdata | output | DATA_W | Array write data |
| memRdata | input | DATA_W | Array combinational read data |
| belowTrip | input | 1 | Supply below deselect threshold |
| belowSwitch | input | 1 | Supply below battery switchover threshold |
| battLowCmp | input | 1 | Battery comparator reports low |
| battSel | output | 1 | Battery supply select |

## Verification
The bench builds the block with REC_CYCLES set to 12, and with the default 13-bit address and FLAG_ADDR of 0x1FFD. The short recovery lets one run cover several power cycles: a full wait, a wait restarted by a one-cycle dip, and checks of the flag with the enable bit and the comparator in different combinations. The full address width puts the flag byte at the top of the real space, next to ordinary bytes at low addresses.

// File: rtl/pfail_pkg.sv
package pfail_pkg;

  typedef enum logic [1:0] {
    PWR_DOWN    = 2'd0,
    PWR_RECOVER = 2'd1,
    PWR_UP      = 2'd2
  } pwrState_t;

  typedef struct packed {
    logic capture;
    logic commit;
    logic readEn;
    logic chkBatt;
  } dpStrobe_t;

endpackage

// File: rtl/pfail_ctrl.sv
module pfail_ctrl
  import pfail_pkg::*;
#(
  parameter int unsigned REC_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selN,
  input  logic       selP,
  input  logic       oeN,
  input  logic       weN,
  input  logic       belowTrip,
  input  logic       belowSwitch,
  output dpStrobe_t  strobe,
  output logic       battSel
);

  localparam int unsigned CNT_W = (REC_CYCLES > 1) ? $clog2(REC_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REC_CYCLES - 1);

  pwrState_t        pwrState, pwrNext;
  logic [CNT_W-1:0] recCnt;
  logic             wrPend;
  logic             accessOk, writeAct, readAct;

  assign accessOk = (pwrState == PWR_UP) && !belowTrip;
  assign writeAct = !selN && selP && !weN;
  assign readAct  = !selN && selP && !oeN && weN;

  always_comb begin
    strobe.capture = accessOk && writeAct;
    strobe.commit  = accessOk && wrPend && !writeAct;
    strobe.readEn  = accessOk && readAct && !strobe.commit;
    strobe.chkBatt = (pwrState == PWR_DOWN) && !belowTrip;
  end

  always_comb begin
    pwrNext = pwrState;
    if (belowTrip) begin
      pwrNext = PWR_DOWN;
    end else begin
      unique case (pwrState)
        PWR_DOWN:    pwrNext = PWR_RECOVER;
        PWR_RECOVER: if (recCnt == CNT_LAST) pwrNext = PWR_UP;
        default:     pwrNext = PWR_UP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrState <= PWR_DOWN;
      recCnt   <= '0;
      wrPend   <= 1'b0;
      battSel  <= 1'b0;
    end else begin
      pwrState <= pwrNext;
      battSel  <= belowSwitch;
      wrPend   <= strobe.capture;
      if (pwrState == PWR_RECOVER && !belowTrip) recCnt <= recCnt + 1'b1;
      else                                       recCnt <= '0;
    end
  end

  assert_down_blocks_R4: assert property (@(posedge clk) disable iff (!rstN)
    belowTrip |=> (pwrState != PWR_UP));

  assert_recover_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == PWR_UP && $past(pwrState) == PWR_RECOVER) |-> ($past(recCnt) == CNT_LAST));

  assert_battsel_on_R5: assert property (@(posedge clk) disable iff (!rstN)
    belowSwitch |=> battSel);

  assert_battsel_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    !belowSwitch |=> !battSel);

  assert_no_commit_after_fail_R7: assert property (@(posedge clk) disable iff (!rstN)
    belowTrip |=> !strobe.commit);

endmodule

// File: rtl/pfail_dp.sv
module pfail_dp
  import pfail_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned FLAG_ADDR = 'h1FFD,
  parameter int unsigned FLAG_BIT  = 6,
  parameter int unsigned EN_BIT    = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              battLowCmp,
  input  logic              belowTrip,
  input  logic              weN,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              rdDrive,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);

  logic [ADDR_W-1:0] holdAddr;
  logic [DATA_W-1:0] holdData;
  logic              battEn;
  logic              battFlag;
  logic              isFlagByte;
  logic [DATA_W-1:0] merged;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdAddr <= '0;
      holdData <= '0;
      battEn   <= 1'b0;
      battFlag <= 1'b0;
    end else begin
      if (strobe.capture) begin
        holdAddr <= addr;
        holdData <= wrData;
      end
      if (strobe.commit && holdAddr == FLAG_A) battEn <= holdData[EN_BIT];
      if (strobe.chkBatt) battFlag <= battEn && battLowCmp;
    end
  end

  assign isFlagByte = (addr == FLAG_A);

  for (genvar b = 0; b < DATA_W; b++) begin : g_merge
    if (b == FLAG_BIT) begin : g_flag
      assign merged[b] = isFlagByte ? battFlag : memRdata[b];
    end else begin : g_plain
      assign merged[b] = memRdata[b];
    end
  end

  assign memWe    = strobe.commit;
  assign memAddr  = strobe.commit ? holdAddr : addr;
  assign memWdata = holdData;
  assign rdDrive  = strobe.readEn;
  assign rdData   = strobe.readEn ? merged : '0;

  assert_we_powered_R4: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !belowTrip);

  assert_rd_powered_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdDrive |-> !belowTrip);

  assert_no_drive_on_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdDrive |-> weN);

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.chkBatt |=> $stable(battFlag));

endmodule

// File: rtl/pfail_bus_ctrl.sv
module pfail_bus_ctrl
  import pfail_pkg::*;
#(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned REC_CYCLES = 16,
  parameter int unsigned FLAG_ADDR  = 'h1FFD,
  parameter int unsigned FLAG_BIT   = 6,
  parameter int unsigned EN_BIT     = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              selP,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              belowTrip,
  input  logic              belowSwitch,
  input  logic              battLowCmp,
  output logic              battSel
);

  dpStrobe_t strobe;

  pfail_ctrl #(
    .REC_CYCLES(REC_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .selN       (selN),
    .selP       (selP),
    .oeN        (oeN),
    .weN        (weN),
    .belowTrip  (belowTrip),
    .belowSwitch(belowSwitch),
    .strobe     (strobe),
    .battSel    (battSel)
  );

  pfail_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .FLAG_ADDR(FLAG_ADDR),
    .FLAG_BIT (FLAG_BIT),
    .EN_BIT   (EN_BIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .addr      (addr),
    .wrData    (wrData),
    .memRdata  (memRdata),
    .battLowCmp(battLowCmp),
    .belowTrip (belowTrip),
    .weN       (weN),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .rdDrive   (rdDrive),
    .rdData    (rdData)
  );

endmodule

// File: tb/sim_pfail_bus_ctrl.sv
`timescale 1ns/1ps
module sim_pfail_bus_ctrl;

  localparam int AW  = 13;
  localparam int DW  = 8;
  localparam int REC = 12;
  localparam int FLAG = 'h1FFD;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selN = 1'b1, selP = 1'b0, oeN = 1'b1, weN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic rdDrive, memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata, memRdata;
  logic belowTrip = 1'b0, belowSwitch = 1'b0, battLowCmp = 1'b0;
  logic battSel;

  always #2 clk = ~clk;

  pfail_bus_ctrl #(.ADDR_W(AW), .DATA_W(DW), .REC_CYCLES(REC), .FLAG_ADDR(FLAG)) u0 (
    .clk(clk), .rstN(rstN), .selN(selN), .selP(selP), .oeN(oeN), .weN(weN),
    .addr(addr), .wrData(wrData), .rdData(rdData), .rdDrive(rdDrive),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .belowTrip(belowTrip), .belowSwitch(belowSwitch), .battLowCmp(battLowCmp),
    .battSel(battSel)
  );

  // external array (out of scope of the block)
  logic [DW-1:0] memArr [0:(1<<AW)-1];
  assign memRdata = memArr[memAddr];
  always @(posedge clk) if (memWe) memArr[memAddr] <= memWdata;

  // reference model
  logic [DW-1:0] refMem [0:(1<<AW)-1];
  int phase;   // 0 down, 1 waiting, 2 open
  int waitCnt;
  bit pend;
  int pendAddr, pendData;
  bit battEn, flagM, bsExp;

  int vectors = 0;
  int miscompares = 0;
  string curReq = "R9";
  bit finished = 0;

  function automatic bit wAct();
    return !selN && selP && !weN;
  endfunction

  function automatic bit openNow();
    return phase == 2 && !belowTrip;
  endfunction

  function automatic bit commitNow();
    return openNow() && pend && !wAct();
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase = 0; waitCnt = 0; pend = 0; battEn = 0; flagM = 0; bsExp = 0;
    end else begin
      bsExp = belowSwitch;
      if (commitNow()) begin
        refMem[pendAddr] = pendData[DW-1:0];
        if (pendAddr == FLAG) battEn = pendData[7];
      end
      if (openNow() && wAct()) begin
        pend = 1; pendAddr = int'(addr); pendData = int'(wrData);
      end else begin
        pend = 0;
      end
      if (belowTrip) begin
        phase = 0;
      end else if (phase == 0) begin
        phase = 1; waitCnt = 0; flagM = battEn && battLowCmp;
      end else if (phase == 1) begin
        if (waitCnt == REC - 1) phase = 2;
        else waitCnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit eDrive, eWe;
      logic [DW-1:0] eData;
      eWe = commitNow();
      eDrive = openNow() && !selN && selP && !oeN && weN && !eWe;
      eData = '0;
      if (eDrive) begin
        eData = refMem[addr];
        if (int'(addr) == FLAG) eData[6] = flagM;
      end
      vectors++;
      if (rdDrive !== eDrive || rdData !== eData || memWe !== eWe || battSel !== bsExp) begin
        miscompares++;
        $display("FAIL %s t=%0t actual drv=%b data=%h we=%b bs=%b expected drv=%b data=%h we=%b bs=%b",
                 curReq, $time, rdDrive, rdData, memWe, battSel, eDrive, eData, eWe, bsExp);
      end else if (eWe && (memAddr !== pendAddr[AW-1:0] || memWdata !== pendData[DW-1:0])) begin
        miscompares++;
        $display("FAIL %s commit actual addr=%h data=%h expected addr=%h data=%h",
                 curReq, memAddr, memWdata, pendAddr[AW-1:0], pendData[DW-1:0]);
      end
    end
  end

  task automatic cyc(input logic s1, input logic s2, input logic o, input logic w,
                     input int a, input int d);
    selN = s1; selP = s2; oeN = o; weN = w;
    addr = a[AW-1:0]; wrData = d[DW-1:0];
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 1, 1, 0, 0);
  endtask

  task automatic finish();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin
      memArr[i] = DW'(i * 7 + 3);
      refMem[i] = DW'(i * 7 + 3);
    end
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    vectors++;
    if (rdDrive !== 1'b0 || memWe !== 1'b0 || battSel !== 1'b0) begin
      miscompares++;
      $display("FAIL R9 reset actual drv=%b we=%b bs=%b expected 0 0 0", rdDrive, memWe, battSel);
    end
    rstN = 1'b1;
    // R6: bus attempts during the recovery wait are ignored
    curReq = "R6";
    cyc(0, 1, 1, 0, 20, 8'h99);
    cyc(1, 0, 1, 1, 0, 0);
    for (int i = 0; i < REC - 3; i++) cyc(0, 1, 0, 1, 20, 0);
    idle(3);
    // R1: write, last data wins, commit at end
    curReq = "R1";
    cyc(0, 1, 1, 0, 5, 8'h11);
    cyc(0, 1, 1, 0, 5, 8'hA5);
    idle(1);
    // R2: reads and non-driving combinations
    curReq = "R2";
    cyc(0, 1, 0, 1, 5, 0);
    cyc(0, 1, 0, 1, 20, 0);
    cyc(0, 1, 1, 1, 5, 0);
    cyc(0, 0, 0, 1, 5, 0);
    cyc(1, 1, 0, 1, 5, 0);
    // R3: strobe falls during a read, then commit cycle with read request
    curReq = "R3";
    cyc(0, 1, 0, 1, 5, 0);
    cyc(0, 1, 0, 0, 5, 8'h77);
    cyc(0, 1, 0, 1, 5, 0);
    cyc(0, 1, 0, 1, 5, 0);
    idle(1);
    cyc(0, 1, 0, 0, 6, 8'h3C);
    idle(1);
    cyc(0, 1, 0, 1, 6, 0);
    // R8: enable bit set, bit 6 written but reads back the flag (0)
    curReq = "R8";
    cyc(0, 1, 1, 0, FLAG, 8'hC0);
    idle(1);
    cyc(0, 1, 0, 1, FLAG, 0);
    // R7 + R4 + R5: power fails mid-write, battery switch, ignored inputs
    curReq = "R7";
    battLowCmp = 1'b1;
    cyc(0, 1, 1, 0, 9, 8'h33);
    belowTrip = 1'b1;
    cyc(0, 1, 1, 0, 9, 8'h33);
    curReq = "R4";
    cyc(0, 1, 0, 1, 9, 0);
    cyc(0, 1, 1, 0, 10, 8'h44);
    curReq = "R5";
    belowSwitch = 1'b1;
    idle(4);
    belowSwitch = 1'b0;
    idle(2);
    curReq = "R4";
    cyc(0, 1, 0, 1, 5, 0);
    belowTrip = 1'b0;
    // R6: dip during wait restarts the count
    curReq = "R6";
    idle(5);
    belowTrip = 1'b1;
    cyc(0, 1, 0, 1, 5, 0);
    belowTrip = 1'b0;
    for (int i = 0; i < REC + 1; i++) cyc(0, 1, 0, 1, 5, 0);
    // R8: flag now set; R7: aborted write left byte 9 intact
    curReq = "R8";
    cyc(0, 1, 0, 1, FLAG, 0);
    curReq = "R7";
    cyc(0, 1, 0, 1, 9, 0);
    cyc(0, 1, 0, 1, 10, 0);
    // R8: comparator passes on next power-up -> flag clears
    curReq = "R8";
    battLowCmp = 1'b0;
    belowTrip = 1'b1; idle(2); belowTrip = 1'b0;
    idle(REC + 2);
    cyc(0, 1, 0, 1, FLAG, 0);
    // R8: enable cleared, comparator low -> flag stays 0
    cyc(0, 1, 1, 0, FLAG, 8'h40);
    idle(1);
    battLowCmp = 1'b1;
    belowTrip = 1'b1; idle(2); belowTrip = 1'b0;
    idle(REC + 2);
    cyc(0, 1, 0, 1, FLAG, 0);
    idle(2);
    finish();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog %s actual=hung expected=done", curReq);
      finish();
    end
  end

endmodule